// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit turns a segment selector and an offset into a physical bus address. It has two translation modes that share one datapath. In real mode, a 16-bit segment value is multiplied by sixteen and added to the low 16 bits of the offset. The sum wraps at 20 bits. In protected mode, the low bits of the segment value index a 16-entry on-chip descriptor table. The address is the descriptor base multiplied by sixteen plus the full 32-bit offset, which gives a 36-bit address. Before any address is issued, the access is checked against the descriptor's presence, privilege, rights, type and limit.

The segment value comes from one of three places:
- the data segment input, by default;
- the stack segment input, when the base register of the access is the stack pointer or the frame pointer;
- an explicit override value supplied with the request, which replaces the default.

A result appears one cycle after each request, together with a 2-bit fault code. Descriptors are loaded through a synchronous write port.

Top module: `seg_addr_gen`

## Requirements
- R1: With `protMode` low, `addrOut` = (segment × 16 + `offset[15:0]`) mod 2^20, zero-extended to 36 bits. Offset bits above 15 have no effect, and no fault is raised.
- R2: `baseReg` value 4 (stack pointer) or 5 (frame pointer) selects `stackSeg`. Every other code, 0–3 and 6–15, selects `dataSeg`. Code 15 stands for an absolute address with no base register.
- R3: When `ovrEn` is high, `ovrSeg` is used as the segment regardless of `baseReg`.
- R4: With `protMode` high and no fault, `addrOut` = (descriptor base × 16 + `offset`) mod 2^36. There is no wrap at 20 bits.
- R5: A descriptor fault (code 1) is raised in protected mode in two cases: segment bits [15:4] are nonzero, or the entry selected by bits [3:0] is not present. All entries are not present after reset.
- R6: A privilege fault (code 2) is raised when `cpl` is numerically greater than the descriptor privilege level.
- R7: An access fault (code 3) is raised when `offset` is greater than the limit, or when the rights do not allow the access kind. Rights bit 0 is read, bit 1 is write and bit 2 is execute. Kind 0 (read) needs bit 0. Kind 1 (write) needs bit 1 and a data segment. Kind 2 (fetch) needs bit 2 and a code segment. Kind 3 always faults.
- R8: When several faults apply, the descriptor fault is reported over the privilege fault, and the privilege fault over the access fault.
- R9: `respValid` is high exactly one cycle after each cycle with `reqValid` high, and low otherwise. When `fault` is nonzero, `addrOut` is 0.
- R10: A table write becomes visible to lookups from the next cycle. A lookup of the same entry in the write cycle sees the old contents.
- R11: During reset, `respValid`, `addrOut` and `fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request |
| protMode | input | 1 | 1 = protected (descriptor) mode, 0 = real mode |
| baseReg | input | 4 | Base register code of the access (4 = stack pointer, 5 = frame pointer, 15 = absolute) |
| ovrEn | input | 1 | Use the override segment |
| ovrSeg | input | 16 | Override segment value |
| dataSeg | input | 16 | Data segment value |
| stackSeg | input | 16 | Stack segment value |
| offset | input | 32 | Offset |
| accKind | input | 2 | 0 read, 1 write, 2 fetch, 3 invalid |
| cpl | input | 2 | Current privilege level |
| dtWrEn | input | 1 | Descriptor write strobe |
| dtWrIdx | input | 4 | Descriptor entry to write |
| dtWrBase | input | 32 | Descriptor base |
| dtWrLimit | input | 32 | Highest valid offset |
| dtWrDpl | input | 2 | Descriptor privilege level |
| dtWrRights | input | 3 | Rights: bit0 read, bit1 write, bit2 execute |
| dtWrIsCode | input | 1 | 1 = code segment, 0 = data segment |
| dtWrPresent | input | 1 | Entry present |
| respValid | output | 1 | Result valid |
| addrOut | output | 36 | Physical address, 0 on fault |
| fault | output | 2 | 0 none, 1 descriptor, 2 privilege, 3 access |

## Verification
A corrupted descriptor entry, or a wrong default-segment choice, shows up on the very next response as a wrong address or a wrong fault code. The sweeps therefore cover every entry, every privilege level and every access kind, with offsets at the limit and one past it. A fault-priority error appears as the wrong nonzero code on combinations where several faults apply. A stale or early table write appears on the one response issued in the same cycle as the write. A 20-bit wrap applied in the wrong mode truncates the high address bits on the first affected request.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W    = 16;
  localparam int OFF_W    = 32;
  localparam int BASE_W   = 32;
  localparam int NUM_DESC = 16;
  localparam int IDX_W    = $clog2(NUM_DESC);
  localparam int REAL_W   = SEG_W + 4;
  localparam int ADDR_W   = BASE_W + 4;
  localparam int BREG_W   = 4;

  localparam logic [BREG_W-1:0] REG_SP = 4'd4;
  localparam logic [BREG_W-1:0] REG_BP = 4'd5;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_DESC   = 2'd1,
    FLT_PRIV   = 2'd2,
    FLT_ACCESS = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_BAD   = 2'd3
  } acc_e;

  typedef struct packed {
    logic              present;
    logic [1:0]        dpl;
    logic [2:0]        rights;   // bit0 read, bit1 write, bit2 execute
    logic              isCode;
    logic [OFF_W-1:0]  limit;
    logic [BASE_W-1:0] base;
  } desc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   load;
    logic   prot;
    fault_e fault;
  } strobe_t;
endpackage

// File: rtl/seg_desc_table.sv
module seg_desc_table
  import seg_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  desc_t            wrDesc,
  input  logic [IDX_W-1:0] rdIdx,
  output desc_t            rdDesc
);
  desc_t entries [NUM_DESC];

  generate
    for (genvar gi = 0; gi < NUM_DESC; gi++) begin : g_entry
      always_ff @(posedge clk) begin
        if (!rstN) entries[gi] <= '0;
        else if (wrEn && wrIdx == IDX_W'(gi)) entries[gi] <= wrDesc;
      end
    end
  endgenerate

  // read is combinational from current contents: same-cycle write is not seen
  assign rdDesc = entries[rdIdx];

  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> entries[$past(wrIdx)] == $past(wrDesc))
    else $error("table write did not land");
endmodule

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              protMode,
  input  logic [BREG_W-1:0] baseReg,
  input  logic              ovrEn,
  input  logic [SEG_W-1:0]  ovrSeg,
  input  logic [SEG_W-1:0]  dataSeg,
  input  logic [SEG_W-1:0]  stackSeg,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        accKind,
  input  logic [1:0]        cpl,
  input  logic              descPresent,
  input  logic [1:0]        descDpl,
  input  logic [2:0]        descRights,
  input  logic              descIsCode,
  input  logic [OFF_W-1:0]  descLimit,
  output logic [SEG_W-1:0]  segSel,
  output strobe_t           stb
);
  logic   pickStack;
  logic   selHigh;
  logic   rightsOk;
  fault_e faultNext;

  always_comb begin
    pickStack = (baseReg == REG_SP) || (baseReg == REG_BP);
    segSel    = ovrEn ? ovrSeg : (pickStack ? stackSeg : dataSeg);
    selHigh   = |segSel[SEG_W-1:IDX_W];
    unique case (acc_e'(accKind))
      ACC_READ:  rightsOk = descRights[0];
      ACC_WRITE: rightsOk = descRights[1] && !descIsCode;
      ACC_FETCH: rightsOk = descRights[2] && descIsCode;
      default:   rightsOk = 1'b0;
    endcase
    faultNext = FLT_NONE;
    if (protMode) begin
      if (selHigh || !descPresent)              faultNext = FLT_DESC;
      else if (cpl > descDpl)                   faultNext = FLT_PRIV;
      else if (!rightsOk || offset > descLimit) faultNext = FLT_ACCESS;
    end
    stb.load  = reqValid;
    stb.prot  = protMode;
    stb.fault = faultNext;
  end

  p_real_never_faults_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !protMode) |-> stb.fault == FLT_NONE)
    else $error("real mode fault");

  p_limit_guard_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && protMode && offset > descLimit) |-> stb.fault != FLT_NONE)
    else $error("offset above limit accepted");

  p_override_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    ovrEn |-> segSel == ovrSeg)
    else $error("override ignored");
endmodule

// File: rtl/seg_addr_datapath.sv
module seg_addr_datapath
  import seg_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [SEG_W-1:0]  segSel,
  input  logic [OFF_W-1:0]  offset,
  input  logic [BASE_W-1:0] descBase,
  output logic              respValid,
  output logic [ADDR_W-1:0] addrOut,
  output logic [1:0]        fault
);
  logic [REAL_W-1:0] realSum;
  logic [ADDR_W-1:0] protSum;
  logic [ADDR_W-1:0] nextAddr;
  logic              modeQ;

  always_comb begin
    realSum  = {segSel, 4'b0000} + REAL_W'(offset[SEG_W-1:0]);
    protSum  = {descBase, 4'b0000} + ADDR_W'(offset);
    if (stb.fault != FLT_NONE) nextAddr = '0;
    else if (stb.prot)         nextAddr = protSum;
    else                       nextAddr = ADDR_W'(realSum);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      addrOut   <= '0;
      fault     <= FLT_NONE;
      modeQ     <= 1'b0;
    end else begin
      respValid <= stb.load;
      modeQ     <= stb.prot;
      if (stb.load) begin
        addrOut <= nextAddr;
        fault   <= stb.fault;
      end else begin
        addrOut <= '0;
        fault   <= FLT_NONE;
      end
    end
  end

  p_quiet_on_fault_r9: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && fault != FLT_NONE) |-> addrOut == '0)
    else $error("address issued with fault");

  p_real_width_r1: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !modeQ) |-> addrOut[ADDR_W-1:REAL_W] == '0)
    else $error("real address exceeds 20 bits");

  p_resp_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> respValid)
    else $error("missing response");

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> (!respValid && addrOut == '0))
    else $error("response without request");
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              protMode,
  input  logic [BREG_W-1:0] baseReg,
  input  logic              ovrEn,
  input  logic [SEG_W-1:0]  ovrSeg,
  input  logic [SEG_W-1:0]  dataSeg,
  input  logic [SEG_W-1:0]  stackSeg,
  input  logic [OFF_W-1:0]  offset,
  input  logic [1:0]        accKind,
  input  logic [1:0]        cpl,
  input  logic              dtWrEn,
  input  logic [IDX_W-1:0]  dtWrIdx,
  input  logic [BASE_W-1:0] dtWrBase,
  input  logic [OFF_W-1:0]  dtWrLimit,
  input  logic [1:0]        dtWrDpl,
  input  logic [2:0]        dtWrRights,
  input  logic              dtWrIsCode,
  input  logic              dtWrPresent,
  output logic              respValid,
  output logic [ADDR_W-1:0] addrOut,
  output logic [1:0]        fault
);
  desc_t            wrDesc;
  desc_t            curDesc;
  logic [SEG_W-1:0] segSel;
  strobe_t          stb;

  assign wrDesc = '{present: dtWrPresent, dpl: dtWrDpl, rights: dtWrRights,
                    isCode: dtWrIsCode, limit: dtWrLimit, base: dtWrBase};

  seg_desc_table u_table (
    .clk(clk), .rstN(rstN),
    .wrEn(dtWrEn), .wrIdx(dtWrIdx), .wrDesc(wrDesc),
    .rdIdx(segSel[IDX_W-1:0]), .rdDesc(curDesc)
  );

  seg_addr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .protMode(protMode), .baseReg(baseReg),
    .ovrEn(ovrEn), .ovrSeg(ovrSeg), .dataSeg(dataSeg), .stackSeg(stackSeg),
    .offset(offset), .accKind(accKind), .cpl(cpl),
    .descPresent(curDesc.present), .descDpl(curDesc.dpl),
    .descRights(curDesc.rights), .descIsCode(curDesc.isCode),
    .descLimit(curDesc.limit),
    .segSel(segSel), .stb(stb)
  );

  seg_addr_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .segSel(segSel),
    .offset(offset), .descBase(curDesc.base),
    .respValid(respValid), .addrOut(addrOut), .fault(fault)
  );
endmodule

// File: tb/seg_addr_gen_bench.sv
module seg_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, protMode = 1'b0, ovrEn = 1'b0;
  logic [3:0]  baseReg = '0;
  logic [15:0] ovrSeg = '0, dataSeg = '0, stackSeg = '0;
  logic [31:0] offset = '0;
  logic [1:0]  accKind = '0, cpl = '0;
  logic        dtWrEn = 1'b0, dtWrIsCode = 1'b0, dtWrPresent = 1'b0;
  logic [3:0]  dtWrIdx = '0;
  logic [31:0] dtWrBase = '0, dtWrLimit = '0;
  logic [1:0]  dtWrDpl = '0;
  logic [2:0]  dtWrRights = '0;
  logic        respValid;
  logic [35:0] addrOut;
  logic [1:0]  fault;

  int total = 0, bad = 0;
  bit done = 0;

  // bench-side copy of what was written to the table
  logic [31:0] mBase [16];
  logic [31:0] mLim  [16];
  logic [1:0]  mDpl  [16];
  logic [2:0]  mRt   [16];
  logic        mCode [16];
  logic        mPres [16];

  always #10 clk = ~clk;

  seg_addr_gen u_seg_addr_gen (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .protMode(protMode),
    .baseReg(baseReg), .ovrEn(ovrEn), .ovrSeg(ovrSeg), .dataSeg(dataSeg),
    .stackSeg(stackSeg), .offset(offset), .accKind(accKind), .cpl(cpl),
    .dtWrEn(dtWrEn), .dtWrIdx(dtWrIdx), .dtWrBase(dtWrBase),
    .dtWrLimit(dtWrLimit), .dtWrDpl(dtWrDpl), .dtWrRights(dtWrRights),
    .dtWrIsCode(dtWrIsCode), .dtWrPresent(dtWrPresent),
    .respValid(respValid), .addrOut(addrOut), .fault(fault)
  );

  task automatic checkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pickSeg(input logic [3:0] br, input logic oe, input logic [15:0] os);
    if (oe) return os;                        // R3
    if (br == 4'd4 || br == 4'd5) return stackSeg; // R2
    return dataSeg;
  endfunction

  task automatic predict(input logic prot, input logic [15:0] seg, input logic [31:0] off,
                         input logic [1:0] kind, input logic [1:0] pl,
                         output logic [1:0] f, output logic [35:0] a);
    longint t;
    logic [3:0] ix;
    logic ok;
    f = 2'd0; a = '0;
    if (!prot) begin
      t = longint'(seg) * 16 + longint'(off[15:0]);
      a = 36'(t % 64'd1048576);
    end else begin
      ix = seg[3:0];
      if ((seg >> 4) != 0 || !mPres[ix]) f = 2'd1;
      else if (pl > mDpl[ix]) f = 2'd2;
      else begin
        case (kind)
          2'd0: ok = mRt[ix][0];
          2'd1: ok = mRt[ix][1] && !mCode[ix];
          2'd2: ok = mRt[ix][2] && mCode[ix];
          default: ok = 1'b0;
        endcase
        if (!ok || off > mLim[ix]) f = 2'd3;
        else begin
          t = longint'(mBase[ix]) * 16 + longint'(off);
          a = 36'(t % 64'd68719476736);
        end
      end
    end
  endtask

  task automatic writeEntry(input int ix, input logic [31:0] b, input logic [31:0] l,
                            input logic [1:0] d, input logic [2:0] r, input logic c, input logic p);
    dtWrEn = 1; dtWrIdx = 4'(ix); dtWrBase = b; dtWrLimit = l;
    dtWrDpl = d; dtWrRights = r; dtWrIsCode = c; dtWrPresent = p;
    @(negedge clk);
    dtWrEn = 0;
    mBase[ix] = b; mLim[ix] = l; mDpl[ix] = d; mRt[ix] = r; mCode[ix] = c; mPres[ix] = p;
  endtask

  task automatic doReq(input string tag, input logic prot, input logic [3:0] br,
                       input logic oe, input logic [15:0] os, input logic [31:0] off,
                       input logic [1:0] kind, input logic [1:0] pl);
    logic [1:0] ef;
    logic [35:0] ea;
    predict(prot, pickSeg(br, oe, os), off, kind, pl, ef, ea);
    reqValid = 1; protMode = prot; baseReg = br; ovrEn = oe; ovrSeg = os;
    offset = off; accKind = kind; cpl = pl;
    @(negedge clk);
    reqValid = 0;
    checkEq({tag, " valid R9"}, 64'(respValid), 64'd1);
    checkEq({tag, " fault"}, 64'(fault), 64'(ef));
    checkEq({tag, " addr"}, 64'(addrOut), 64'(ea));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mBase[i] = '0; mLim[i] = '0; mDpl[i] = '0; mRt[i] = '0; mCode[i] = 0; mPres[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R11 reset state
    checkEq("R11 respValid", 64'(respValid), 0);
    checkEq("R11 addrOut", 64'(addrOut), 0);
    checkEq("R11 fault", 64'(fault), 0);
    rstN = 1;
    @(negedge clk);

    // R1 real-mode sweep, junk in upper offset bits
    for (int s = 0; s < 16; s++) begin
      for (int o = 0; o < 16; o++) begin
        dataSeg = 16'(s * 16'h1111);
        doReq("R1 real", 0, 4'd0, 0, 16'h0, 32'(o * 32'h1111) | 32'(o << 20), 2'(o), 2'(s));
      end
    end
    dataSeg = 16'hFFFF;
    doReq("R1 wrap", 0, 4'd0, 0, 16'h0, 32'h0000FFFF, 2'd0, 2'd0);
    checkEq("R1 wrap value", 64'(addrOut), 64'h0FFEF);

    // R2 default segment per base register
    dataSeg = 16'h1234; stackSeg = 16'hABCD;
    for (int b = 0; b < 16; b++)
      doReq("R2 default seg", 0, 4'(b), 0, 16'h0, 32'h10, 2'd0, 2'd0);

    // R3 override
    for (int b = 0; b < 16; b++)
      doReq("R3 override", 0, 4'(b), 1, 16'h0F0F, 32'h22, 2'd0, 2'd0);

    // R9 idle
    @(negedge clk);
    checkEq("R9 idle valid", 64'(respValid), 0);
    checkEq("R9 idle addr", 64'(addrOut), 0);

    // R5 table empty after reset
    doReq("R5 not present", 1, 4'd0, 1, 16'h0003, 32'h0, 2'd0, 2'd0);
    checkEq("R5 reset fault code", 64'(fault), 64'd1);

    // load table
    for (int i = 0; i < 16; i++) begin
      if (i == 14) writeEntry(i, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd2, 3'd6, 1'b1, 1'b1);
      else writeEntry(i, 32'(i) * 32'h0111_1111 + 32'h10, 32'(i) * 32'h100 + 32'hFF,
                      2'(i % 4), 3'(i % 8), i[3], (i != 15));
    end

    // R4-R8 sweep: entries, out-of-range selector 16, privileges, kinds, offsets
    for (int s = 0; s < 17; s++) begin
      for (int p = 0; p < 4; p++) begin
        for (int k = 0; k < 4; k++) begin
          for (int q = 0; q < 3; q++) begin
            logic [31:0] lim;
            logic [31:0] off;
            lim = mLim[s % 16];
            off = (q == 0) ? 32'h0 : (q == 1) ? lim : lim + 32'd1;
            doReq("R4-R8 prot", 1, 4'd0, 1, 16'(s), off, 2'(k), 2'(p));
          end
        end
      end
    end

    // R4 no 20-bit wrap, R6/R7/R8 specific points
    doReq("R4 wide", 1, 4'd0, 1, 16'd14, 32'hFFFF_FFFF, 2'd2, 2'd0);
    checkEq("R4 wide value", 64'(addrOut), 64'h0_FFFF_FFEF);
    doReq("R6 priv", 1, 4'd0, 1, 16'd1, 32'h0, 2'd0, 2'd2);
    checkEq("R6 code", 64'(fault), 64'd2);
    doReq("R7 write to code", 1, 4'd0, 1, 16'd14, 32'h0, 2'd1, 2'd0);
    checkEq("R7 code", 64'(fault), 64'd3);
    doReq("R8 desc over priv", 1, 4'd0, 1, 16'd15, 32'h0, 2'd3, 2'd3);
    checkEq("R8 code", 64'(fault), 64'd1);

    // R10 same-cycle write and lookup of entry 5
    begin
      logic [35:0] oldA;
      oldA = 36'(longint'(mBase[5]) * 16);
      dtWrEn = 1; dtWrIdx = 4'd5; dtWrBase = 32'h0000_0ABC; dtWrLimit = 32'hFFFF;
      dtWrDpl = 2'd3; dtWrRights = 3'd1; dtWrIsCode = 0; dtWrPresent = 1;
      reqValid = 1; protMode = 1; ovrEn = 1; ovrSeg = 16'd5; offset = 0; accKind = 0; cpl = 0;
      @(negedge clk);
      dtWrEn = 0; reqValid = 0;
      checkEq("R10 old contents fault", 64'(fault), 0);
      checkEq("R10 old contents addr", 64'(addrOut), 64'(oldA));
      mBase[5] = 32'h0000_0ABC; mLim[5] = 32'hFFFF; mDpl[5] = 2'd3; mRt[5] = 3'd1;
      mCode[5] = 0; mPres[5] = 1;
      doReq("R10 new contents", 1, 4'd0, 1, 16'd5, 32'h4, 2'd0, 2'd0);
      checkEq("R10 new addr", 64'(addrOut), 64'h0ABC4);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule